// File: doc/BRIEF.md
# Checkpointed Register File

This register file keeps two copies of every architectural register: a working copy that reads and writes reach, and a checkpoint copy that holds the last state declared safe. A group of speculatively reordered operations writes only the working copies. When the group finishes cleanly, a commit pulse copies all working registers into their checkpoints at once. When a fault occurs inside the group, a rollback pulse restores every working register from its checkpoint. Software then re-executes the group in order.

The file has two combinational read ports that return working values and one synchronous write port. A third read port returns the checkpoint value of a selected register, so that the saved state can be observed.

Top module: `ckpt_regfile`

## Requirements
- R1: After reset every working and every checkpoint register reads zero.
- R2: Both read ports return the working value of their addressed register combinationally. A write becomes visible from the clock edge that takes it.
- R3: A write with `wr_en` high and neither `commit` nor `rollback` high changes only the working copy of register `wr_addr`. The checkpoint copy stays unchanged.
- R4: A cycle with `commit` high and `rollback` low copies every working register into its checkpoint on one clock edge.
- R5: A cycle with `rollback` high copies every checkpoint register into its working copy on one clock edge.
- R6: When `commit` and `rollback` are both high, only the rollback takes effect. The checkpoints keep their previous values.
- R7: A write in the same cycle as a commit or a rollback is ignored. The working copy of that register takes its value from the bulk operation, and no register holds the write data.
- R8: Registers that a write does not address keep both of their copies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_addr_a | input | AW | Read port A address |
| rd_data_a | output | DW | Working value of register rd_addr_a |
| rd_addr_b | input | AW | Read port B address |
| rd_data_b | output | DW | Working value of register rd_addr_b |
| wr_en | input | 1 | Write enable |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| commit | input | 1 | Copy all working registers to their checkpoints |
| rollback | input | 1 | Copy all checkpoints to their working registers |
| dbg_addr | input | AW | Checkpoint read address |
| dbg_data | output | DW | Checkpoint value of register dbg_addr |

## Verification
The hardest situation to reach is a single cycle where a write collides with a bulk operation while working and checkpoint values differ across many registers. The bench therefore commits a known pattern first. It then overwrites every working register with a second pattern, so each register has two different copies. Only after that does it pulse commit, rollback, or both together with a write. Each register is then read back through the read ports and the checkpoint port.

// File: rtl/ckpt_regfile.sv
module ckpt_regfile #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr_a,
  output logic [DW-1:0] rd_data_a,
  input  logic [AW-1:0] rd_addr_b,
  output logic [DW-1:0] rd_data_b,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          commit,
  input  logic          rollback,
  input  logic [AW-1:0] dbg_addr,
  output logic [DW-1:0] dbg_data
);

  logic [DW-1:0] work [NREG];
  logic [DW-1:0] shad [NREG];

  wire do_rb  = rollback;
  wire do_cm  = commit & ~rollback;
  wire do_wr  = wr_en & ~commit & ~rollback;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        work[i] <= '0;
        shad[i] <= '0;
      end
    end else if (do_rb) begin
      for (int i = 0; i < NREG; i++) work[i] <= shad[i];
    end else if (do_cm) begin
      for (int i = 0; i < NREG; i++) shad[i] <= work[i];
    end else if (do_wr) begin
      work[wr_addr] <= wr_data;
    end
  end

  assign rd_data_a = work[rd_addr_a];
  assign rd_data_b = work[rd_addr_b];
  assign dbg_data  = shad[dbg_addr];

  logic seen_rst;
  always_ff @(posedge clk) seen_rst <= seen_rst | ~rst_n;

  AST_WRITE_SKIPS_SHADOW: assert property (@(posedge clk) disable iff (!rst_n || !seen_rst)
    (wr_en && !commit && !rollback) |=> (dbg_data == $past(dbg_data)) || (dbg_addr != $past(dbg_addr))); // R3
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n || !seen_rst)
    (wr_en && !commit && !rollback && rd_addr_a == wr_addr) |=> (rd_addr_a != $past(rd_addr_a)) || (rd_data_a == $past(wr_data))); // R2
  AST_COMMIT_SAVES: assert property (@(posedge clk) disable iff (!rst_n || !seen_rst)
    (commit && !rollback && dbg_addr == rd_addr_a) |=> (dbg_addr != $past(dbg_addr)) || (dbg_data == $past(rd_data_a))); // R4
  AST_ROLLBACK_RESTORES: assert property (@(posedge clk) disable iff (!rst_n || !seen_rst)
    (rollback && dbg_addr == rd_addr_a) |=> (rd_addr_a != $past(rd_addr_a)) || (rd_data_a == $past(dbg_data))); // R5
  AST_BOTH_KEEPS_SHADOW: assert property (@(posedge clk) disable iff (!rst_n || !seen_rst)
    (commit && rollback) |=> (dbg_addr != $past(dbg_addr)) || $stable(dbg_data)); // R6
  AST_RESET_CLEARS: assert property (@(posedge clk)
    (seen_rst && $past(!rst_n)) |-> (rd_data_a == '0 && dbg_data == '0)); // R1

endmodule

// File: tb/ckpt_regfile_bench.sv
module ckpt_regfile_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 16;
  localparam int DW = 32;
  localparam int AW = 4;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] rd_addr_a = 0, rd_addr_b = 0, wr_addr = 0, dbg_addr = 0;
  logic [DW-1:0] rd_data_a, rd_data_b, wr_data = 0, dbg_data;
  logic wr_en = 0, commit = 0, rollback = 0;
  int compared = 0, mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ckpt_regfile #(.NREG(NREG), .DW(DW)) u_ckpt_regfile (
    .clk, .rst_n, .rd_addr_a, .rd_data_a, .rd_addr_b, .rd_data_b,
    .wr_en, .wr_addr, .wr_data, .commit, .rollback, .dbg_addr, .dbg_data);

  function automatic logic [DW-1:0] pat_a(int i); return 32'hA000_0000 + i * 32'h0101; endfunction
  function automatic logic [DW-1:0] pat_b(int i); return 32'h5B00_0000 ^ (i * 32'h1111_0003); endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(); @(posedge clk); #1; endtask

  task automatic idle();
    wr_en = 0; commit = 0; rollback = 0;
  endtask

  task automatic check_all(string req, bit work_a, bit shad_a);
    for (int i = 0; i < NREG; i++) begin
      rd_addr_a = AW'(i); rd_addr_b = AW'(NREG-1-i); dbg_addr = AW'(i); #1;
      check(req, rd_data_a, work_a ? pat_a(i) : pat_b(i));
      check(req, dbg_data, shad_a ? pat_a(i) : pat_b(i));
      check(req, rd_data_b, work_a ? pat_a(NREG-1-i) : pat_b(NREG-1-i));
    end
  endtask

  task automatic fill(bit use_a);
    for (int i = 0; i < NREG; i++) begin
      wr_en = 1; wr_addr = AW'(i); wr_data = use_a ? pat_a(i) : pat_b(i); cyc();
    end
    idle();
  endtask

  task automatic t_reset();
    rst_n = 0; idle(); cyc(); cyc(); rst_n = 1;
    for (int i = 0; i < NREG; i++) begin
      rd_addr_a = AW'(i); dbg_addr = AW'(i); #1;
      check("R1", rd_data_a, '0); check("R1", dbg_data, '0);
    end
  endtask

  task automatic t_write_only();
    wr_en = 1; wr_addr = 3; wr_data = 32'hDEAD_BEEF; rd_addr_a = 3; #1;
    check("R2", rd_data_a, '0);
    cyc(); idle();
    rd_addr_a = 3; rd_addr_b = 4; dbg_addr = 3; #1;
    check("R2", rd_data_a, 32'hDEAD_BEEF);
    check("R3", dbg_data, '0);
    check("R8", rd_data_b, '0);
  endtask

  task automatic t_commit();
    fill(1); commit = 1; cyc(); idle();
    check_all("R4", 1, 1);
    fill(0);
    check_all("R3", 0, 1);
  endtask

  task automatic t_rollback();
    rollback = 1; cyc(); idle();
    check_all("R5", 1, 1);
  endtask

  task automatic t_both();
    fill(0);
    commit = 1; rollback = 1; cyc(); idle();
    check_all("R6", 1, 1);
  endtask

  task automatic t_write_collide();
    fill(0);
    commit = 1; wr_en = 1; wr_addr = 7; wr_data = 32'h1234_5678; cyc(); idle();
    check_all("R7", 0, 0);
    fill(1);
    rollback = 1; wr_en = 1; wr_addr = 9; wr_data = 32'h8765_4321; cyc(); idle();
    check_all("R7", 0, 0);
  endtask

  task automatic t_neighbours();
    wr_en = 1; wr_addr = 5; wr_data = 32'hCAFE_0005; cyc(); idle();
    for (int i = 0; i < NREG; i++) begin
      rd_addr_a = AW'(i); dbg_addr = AW'(i); #1;
      check("R8", rd_data_a, i == 5 ? 32'hCAFE_0005 : pat_b(i));
      check("R8", dbg_data, pat_b(i));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_write_only();
    t_commit();
    t_rollback();
    t_both();
    t_write_collide();
    t_neighbours();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule